// File: doc/BRIEF.md
# Sixteen-Bit Serializer with Frame Timing Generator

This block sits at the transmit end of a serial line interface. It runs entirely on the serial bit clock. Each clock cycle it sends one bit of a 16-bit word out on a single serial output. A free-running phase counter divides the bit clock by sixteen. The counter produces three things: a parallel clock for the upstream logic that supplies the words, a load strobe that moves one word per frame from a four-entry elastic FIFO into the shift register, and a feedback pulse for an external PLL phase comparator. The feedback ratio follows the selected line rate.

Upstream logic returns its copy of the parallel clock together with the data. The block detects each rising edge of that returned clock and writes the word present at that edge into the FIFO. The FIFO absorbs the phase offset between the write side and the load strobe. If upstream produces too many or too few clock edges, the FIFO overflows or underflows. The block then raises a sticky error flag and re-centres its pointers. Two loopback paths are provided. Line loopback sends the recovered receive bit stream back out on the transmitter. Diagnostic loopback sends the transmit bit stream into the receive path.

Top module: `ser16_tx`

## Requirements
- R1: `pclk_o` is low for 8 bit clocks and then high for 8 bit clocks. It is low during the first 8 cycles after reset.
- R2: On every cycle where `par_clk_i` is high and was low in the previous cycle, the value of `par_data_i` in that cycle is written into the FIFO, unless the write overflows.
- R3: The load strobe fires on the last of every 16 cycles, counted from reset. The word it loads appears on `tx_ser_o` most significant bit first. Bit 15 appears in the cycle after the load, and one further bit follows in each cycle after that.
- R4: The FIFO holds 4 words. After reset it starts with two zero-valued entries, so the first two words transmitted are all zeros.
- R5: A write when the FIFO already holds 4 words, with no load in the same cycle, is discarded. It sets `fifo_err_o`, and the read position is moved to two entries behind the write position. `fifo_err_o` then stays high until reset.
- R6: A load when the FIFO is empty loads an all-zero word. It sets `fifo_err_o`, and the read position is moved to two entries behind the write position, counting any write made in the same cycle.
- R7: `fb_clk_o` is high for one cycle in every N. N depends on `rate_sel_i`: code 0 gives 16, code 1 gives 8, code 2 gives 4, code 3 gives 1 (so the output stays high), code 4 gives 10, and any other code gives 16. `fb_clk_o` is high in the first cycle after reset.
- R8: While line loopback is enabled, `tx_ser_o` equals the value `rx_ser_i` had one cycle earlier. The enable itself is registered, so it takes effect one cycle later.
- R9: While diagnostic loopback is enabled, `rx_path_o` carries the transmit shift-register bit. Otherwise it carries `rx_ser_i` delayed by one cycle. The enable is registered in the same way as for R8.
- R10: A synchronous active-high reset clears the phase counter, the shift register, the loopback state and the error flag. `tx_ser_o` is low from reset until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| par_clk_i | input | 1 | Parallel clock returned by upstream; rising edge writes a word |
| par_data_i | input | 16 | Parallel word from upstream |
| rate_sel_i | input | 3 | Line-rate code choosing the feedback divide ratio |
| loop_en_i | input | 1 | Line loopback enable |
| diag_en_i | input | 1 | Diagnostic loopback enable |
| rx_ser_i | input | 1 | Recovered receive serial bit |
| tx_ser_o | output | 1 | Transmit serial bit |
| rx_path_o | output | 1 | Serial bit handed to the receive path |
| pclk_o | output | 1 | Bit clock divided by 16 |
| fb_clk_o | output | 1 | Feedback pulse to the PLL phase comparator |
| fifo_err_o | output | 1 | Sticky FIFO overflow/underflow flag |

## Verification
The hardest condition to reach from the ports is FIFO slip. As long as upstream simply echoes `pclk_o`, writes and loads stay locked at one per frame, and the occupancy only moves between two neighbouring values. The stimulus therefore breaks that lock in two ways. In one phase it toggles `par_clk_i` every cycle, which forces overflows. In another it holds `par_clk_i` low for several frames, which drains the FIFO to underflow. In between, it varies the echo delay and the rate code at random, with random data and receive bits, so that the write point lands at different phases of the frame.

// File: rtl/ser16_pkg.sv
package ser16_pkg;

    localparam int unsigned WORD_W_DEF = 16;
    localparam int unsigned FB_W       = 5;

    typedef enum logic [2:0] {
        RATE_2G488 = 3'd0,
        RATE_1G244 = 3'd1,
        RATE_622M  = 3'd2,
        RATE_155M  = 3'd3,
        RATE_1G25  = 3'd4
    } rate_e;

    // Strobes and clocks derived from the frame phase counter
    typedef struct packed {
        logic load;
        logic pclk;
        logic fb;
    } tmg_s;

    // Registered loopback and receive state
    typedef struct packed {
        logic line;
        logic diag;
        logic rx;
    } lpb_s;

    // Bit-clock cycles per reference-clock cycle for each line rate
    function automatic logic [FB_W-1:0] fb_ratio(input logic [2:0] sel);
        logic [FB_W-1:0] r;
        case (rate_e'(sel))
            RATE_2G488: r = FB_W'(16);
            RATE_1G244: r = FB_W'(8);
            RATE_622M:  r = FB_W'(4);
            RATE_155M:  r = FB_W'(1);
            RATE_1G25:  r = FB_W'(10);
            default:    r = FB_W'(16);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ser16_tmg.sv
module ser16_tmg
    import ser16_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] rate_sel_i,
    output tmg_s       tmg_o
);
    localparam int unsigned CW = $clog2(WORD_W);

    logic [CW-1:0]   ph_q;
    logic [FB_W-1:0] fb_q;
    logic [FB_W-1:0] ratio;
    logic [FB_W-1:0] fb_lim;

    assign ratio  = fb_ratio(rate_sel_i);
    assign fb_lim = ratio - FB_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
            fb_q <= '0;
        end else begin
            ph_q <= ph_q + CW'(1);
            fb_q <= (fb_q >= fb_lim) ? '0 : fb_q + FB_W'(1);
        end
    end

    assign tmg_o.load = (ph_q == CW'(WORD_W - 1));
    assign tmg_o.pclk = (ph_q >= CW'(WORD_W / 2));
    assign tmg_o.fb   = (fb_q == '0);

    AST_FB_SINGLE: assert property (@(posedge clk) disable iff (rst) (tmg_o.fb && ratio > FB_W'(1)) |=> !tmg_o.fb) else $error("feedback pulse longer than one cycle"); // R7
    AST_LOAD_ISOLATED: assert property (@(posedge clk) disable iff (rst) tmg_o.load |=> !tmg_o.load) else $error("back-to-back load strobes"); // R3
    AST_PCLK_AT_LOAD: assert property (@(posedge clk) disable iff (rst) tmg_o.load |=> $fell(tmg_o.pclk)) else $error("parallel clock not falling after load"); // R1

endmodule

// File: rtl/ser16_fifo.sv
module ser16_fifo
    import ser16_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              err_o
);
    localparam int unsigned AW     = $clog2(DEPTH);
    localparam int unsigned PW     = AW + 1;
    localparam int unsigned CENTRE = DEPTH / 2;

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     wp_q, rp_q, wp_nx, occ;
    logic              full, empty, ovf, unf, wr_ok;

    assign occ   = wp_q - rp_q;
    assign full  = (occ == PW'(DEPTH));
    assign empty = (occ == '0);
    assign ovf   = wr_i && !rd_i && full;
    assign unf   = rd_i && empty;
    assign wr_ok = wr_i && !ovf;
    assign wp_nx = wp_q + PW'(wr_ok);

    assign rdata_o = unf ? '0 : mem_q[rp_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= PW'(CENTRE);
            rp_q  <= '0;
            err_o <= 1'b0;
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
        end else begin
            if (wr_ok) mem_q[wp_q[AW-1:0]] <= wdata_i;
            wp_q <= wp_nx;
            if (ovf || unf)  rp_q <= wp_nx - PW'(CENTRE);
            else if (rd_i)   rp_q <= rp_q + PW'(1);
            err_o <= err_o | ovf | unf;
        end
    end

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ <= PW'(DEPTH)) else $error("occupancy beyond depth"); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_o |=> err_o) else $error("error flag cleared without reset"); // R5
    AST_RECENTRE: assert property (@(posedge clk) disable iff (rst) (ovf || unf) |=> (occ == PW'(CENTRE))) else $error("pointers not re-centred"); // R6

endmodule

// File: rtl/ser16_shift.sv
module ser16_shift
    import ser16_pkg::*;
#(
    parameter int unsigned WORD_W = WORD_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              loop_en_i,
    input  logic              diag_en_i,
    input  logic              rx_ser_i,
    output logic              tx_ser_o,
    output logic              rx_path_o
);
    logic [WORD_W-1:0] sh_q;
    lpb_s              lp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            lp_q <= '0;
        end else begin
            sh_q <= load_i ? word_i : {sh_q[WORD_W-2:0], 1'b0};
            lp_q <= '{line: loop_en_i, diag: diag_en_i, rx: rx_ser_i};
        end
    end

    assign tx_ser_o  = lp_q.line ? lp_q.rx : sh_q[WORD_W-1];
    assign rx_path_o = lp_q.diag ? sh_q[WORD_W-1] : lp_q.rx;

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst) !load_i |=> sh_q == {$past(sh_q[WORD_W-2:0]), 1'b0}) else $error("shift register did not advance"); // R3
    AST_LINE_LOOP: assert property (@(posedge clk) disable iff (rst) loop_en_i |=> tx_ser_o == $past(rx_ser_i)) else $error("line loopback bit mismatch"); // R8
    AST_DIAG_RX: assert property (@(posedge clk) disable iff (rst) !diag_en_i |=> rx_path_o == $past(rx_ser_i)) else $error("receive path bit mismatch"); // R9

endmodule

// File: rtl/ser16_tx.sv
module ser16_tx
    import ser16_pkg::*;
#(
    parameter int unsigned WORD_W     = WORD_W_DEF,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_clk_i,
    input  logic [WORD_W-1:0] par_data_i,
    input  logic [2:0]        rate_sel_i,
    input  logic              loop_en_i,
    input  logic              diag_en_i,
    input  logic              rx_ser_i,
    output logic              tx_ser_o,
    output logic              rx_path_o,
    output logic              pclk_o,
    output logic              fb_clk_o,
    output logic              fifo_err_o
);
    tmg_s              tmg;
    logic              pc_q;
    logic              wr;
    logic [WORD_W-1:0] ld_word;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= 1'b0;
        else     pc_q <= par_clk_i;
    end

    assign wr = par_clk_i && !pc_q;

    ser16_tmg #(.WORD_W(WORD_W)) tmg_i (
        .clk        (clk),
        .rst        (rst),
        .rate_sel_i (rate_sel_i),
        .tmg_o      (tmg)
    );

    ser16_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr),
        .wdata_i (par_data_i),
        .rd_i    (tmg.load),
        .rdata_o (ld_word),
        .err_o   (fifo_err_o)
    );

    ser16_shift #(.WORD_W(WORD_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmg.load),
        .word_i    (ld_word),
        .loop_en_i (loop_en_i),
        .diag_en_i (diag_en_i),
        .rx_ser_i  (rx_ser_i),
        .tx_ser_o  (tx_ser_o),
        .rx_path_o (rx_path_o)
    );

    assign pclk_o   = tmg.pclk;
    assign fb_clk_o = tmg.fb;

    AST_WR_EDGE: assert property (@(posedge clk) disable iff (rst) wr |=> !wr) else $error("write strobe held"); // R2

endmodule

// File: tb/ser16_tx_tb_top.sv
`timescale 1ns/1ps
module ser16_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        par_clk = 1'b0;
    logic [15:0] par_data = '0;
    logic [2:0]  rate = '0;
    logic        loop_en = 1'b0, diag_en = 1'b0, rx_ser = 1'b0;
    logic        tx_ser, rx_path, pclk, fb_clk, fifo_err;

    always #2 clk = ~clk;

    ser16_tx dut_i (
        .clk(clk), .rst(rst), .par_clk_i(par_clk), .par_data_i(par_data),
        .rate_sel_i(rate), .loop_en_i(loop_en), .diag_en_i(diag_en), .rx_ser_i(rx_ser),
        .tx_ser_o(tx_ser), .rx_path_o(rx_path), .pclk_o(pclk), .fb_clk_o(fb_clk),
        .fifo_err_o(fifo_err)
    );

    int n_chk = 0, n_bad = 0;

    // Reference state, advanced once per bit clock
    int          m_ph, m_fb, m_wp, m_rp;
    bit          m_pc, m_err, m_line, m_diag, m_rx;
    logic [15:0] m_sh;
    logic [15:0] m_mem [4];
    bit          armed = 0;
    bit [7:0]    hist = '0;

    // Values applied at the next tick
    bit       w_rst = 1, w_loop = 0, w_diag = 0;
    bit [2:0] w_rate = 0;
    int       mode = 0, dly = 0;
    string    tx_tag = "R2", err_tag = "R5";

    function automatic int ratio_of(input bit [2:0] r);
        case (r)
            3'd0: return 16;
            3'd1: return 8;
            3'd2: return 4;
            3'd3: return 1;
            3'd4: return 10;
            default: return 16;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        bit e_tx, e_rxp;
        if (!armed) return;
        e_tx  = m_line ? m_rx : m_sh[15];
        e_rxp = m_diag ? m_sh[15] : m_rx;
        chk(tx_ser === e_tx, m_line ? "R8" : tx_tag, "tx_ser_o", int'(tx_ser), int'(e_tx));
        chk(pclk === (m_ph >= 8), "R1", "pclk_o", int'(pclk), int'(m_ph >= 8));
        chk(fb_clk === (m_fb == 0), "R7", "fb_clk_o", int'(fb_clk), int'(m_fb == 0));
        chk(fifo_err === m_err, err_tag, "fifo_err_o", int'(fifo_err), int'(m_err));
        chk(rx_path === e_rxp, "R9", "rx_path_o", int'(rx_path), int'(e_rxp));
    endtask

    task automatic model_step();
        bit wr, rd, ovf, unf;
        int occ, wp_new;
        logic [15:0] nsh;
        if (rst) begin
            m_ph = 0; m_fb = 0; m_wp = 2; m_rp = 0; m_pc = 0; m_err = 0;
            m_sh = '0; m_line = 0; m_diag = 0; m_rx = 0;
            for (int i = 0; i < 4; i++) m_mem[i] = '0;
        end else begin
            wr  = par_clk && !m_pc;
            rd  = (m_ph == 15);
            occ = (m_wp - m_rp) & 7;
            ovf = wr && !rd && (occ == 4);
            unf = rd && (occ == 0);
            nsh = rd ? (unf ? 16'h0 : m_mem[m_rp % 4]) : {m_sh[14:0], 1'b0};
            wp_new = m_wp;
            if (wr && !ovf) begin
                m_mem[m_wp % 4] = par_data;
                wp_new = (m_wp + 1) & 7;
            end
            if (ovf || unf) m_rp = (wp_new - 2) & 7;
            else if (rd)    m_rp = (m_rp + 1) & 7;
            m_wp  = wp_new;
            m_err = m_err | ovf | unf;
            m_sh  = nsh;
            m_fb  = (m_fb >= ratio_of(rate) - 1) ? 0 : m_fb + 1;
            m_ph  = (m_ph + 1) % 16;
            m_pc  = par_clk;
            m_line = loop_en; m_diag = diag_en; m_rx = rx_ser;
        end
        armed = 1;
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        hist = {hist[6:0], (m_ph >= 8)};
        rst = w_rst; rate = w_rate; loop_en = w_loop; diag_en = w_diag;
        case (mode)
            0: par_clk = hist[dly];
            1: par_clk = ~par_clk;
            default: par_clk = 1'b0;
        endcase
        par_data = 16'($urandom);
        rx_ser   = 1'($urandom);
        model_step();
    endtask

    task automatic do_reset();
        w_rst = 1;
        repeat (3) tick();
        w_rst = 0;
        chk(tx_ser === 1'b0, "R10", "tx_ser_o after reset", int'(tx_ser), 0);
        chk(pclk === 1'b0, "R10", "pclk_o after reset", int'(pclk), 0);
        chk(fb_clk === 1'b1, "R10", "fb_clk_o after reset", int'(fb_clk), 1);
        chk(fifo_err === 1'b0, "R10", "fifo_err_o after reset", int'(fifo_err), 0);
        chk(rx_path === 1'b0, "R10", "rx_path_o after reset", int'(rx_path), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        w_rate = 0; mode = 0; dly = 0;
        do_reset();
        // idle low until the first load, then two zero words
        tx_tag = "R10"; repeat (17) tick();
        tx_tag = "R4";  repeat (32) tick();
        tx_tag = "R2";  repeat (200) tick();
        chk(fifo_err === 1'b0, "R2", "no slip with echoed parallel clock", int'(fifo_err), 0);

        // random rate, echo delay, loopback settings and data
        tx_tag = "R3";
        for (int i = 0; i < 14; i++) begin
            w_rate = 3'($urandom % 8);
            w_loop = 1'($urandom % 2);
            w_diag = 1'($urandom % 2);
            dly    = $urandom % 8;
            repeat (120) tick();
        end

        // overflow: a write edge every two cycles
        w_loop = 0; w_diag = 0; w_rate = 0; dly = 0; mode = 0;
        do_reset();
        tx_tag = "R5"; err_tag = "R5";
        repeat (40) tick();
        mode = 1; repeat (40) tick();
        mode = 0; repeat (5) tick();
        chk(fifo_err === 1'b1, "R5", "overflow flagged", int'(fifo_err), 1);
        repeat (100) tick();
        chk(fifo_err === 1'b1, "R5", "error flag sticky", int'(fifo_err), 1);

        // underflow: upstream clock stalls for several frames
        do_reset();
        tx_tag = "R6"; err_tag = "R6";
        repeat (40) tick();
        mode = 2; repeat (60) tick();
        chk(fifo_err === 1'b1, "R6", "underflow flagged", int'(fifo_err), 1);
        mode = 0; repeat (100) tick();

        do_reset();
        repeat (4) tick();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule